// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers up to 128 level-sensitive peripheral request lines and presents them to a processor as two interrupt outputs: a normal request and a fast request. The lines are split into banks of 32. Each line has an enable bit and a steering bit. Software reads the raw line levels, the enabled normal-request set and the enabled fast-request set through a small 32-bit register port. A wake output tells the power logic that a request is present.

A table of priority slots picks the single most urgent normal request. There is one slot per configured source. Each slot names a source and carries a valid flag, and the lowest-numbered valid slot that names an active, enabled, normal-steered source wins. Its number is reported in an encoded status word. The bank count is a parameter from 1 to 4. Banks, slots and registers beyond the configured count decode as unmapped.

Reads are registered: the data appears one clock after the read strobe, together with a valid flag. Writes take effect at the clock edge that samples them. All pins are plain control and status signals. The register port has no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `plvl_intc`

## Requirements
- R1: After reset, every enable, steering, control and priority-slot register reads zero. The status word reads zero while no line is active.
- R2: The raw register (bank offset 0x10) shows each line's level one clock after the line changes. Writes to it have no effect, and a bit clears only when its line drops.
- R3: The normal-pending register (bank offset 0x00) is raw AND enable AND NOT steer. Writing 0 to the enable register (bank offset 0x04) hides every line of that bank.
- R4: Steering register bit (bank offset 0x08): 0 selects the normal request and 1 selects the fast request. The fast-pending register (bank offset 0x0C) is raw AND enable AND steer.
- R5: `irq_o` is the OR of all normal-pending bits and `fiq_o` is the OR of all fast-pending bits, across every bank.
- R6: When control bit 0 (offset 0x14) is 1, `wake_o` follows enabled pending lines only. When it is 0, `wake_o` follows any raw line.
- R7: Bank b's five registers sit at base 0x000, 0x09C, 0x130 and 0x244 for b = 0 to 3. Control (0x14) and status (0x18) exist only at base 0.
- R8: Priority slot i is at 0x01C+4i for i<32, 0x0B0+4(i-32) for i<64 and 0x144+4(i-64) above that. A slot stores bit 31 as its valid flag and the low 7 source-number bits; every other bit reads back as zero.
- R9: The status word (offset 0x18) carries in bits 30:16 the source named by the lowest-index valid slot whose source is active, enabled and normal-steered. Invalid slots never win.
- R10: Status bit 31 is 1 exactly when some normal-pending bit is set. If no valid slot names such a source, bits 30:16 are zero.
- R11: A line that is disabled or steered to the fast request never appears in the status word.
- R12: Unmapped addresses, including misaligned ones, read zero, and writes to them change no register.
- R13: `rvalid_o` is 1 exactly one clock after `rd_en_i`, with `rdata_o` holding the addressed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32*NUM_BANKS | Level request lines |
| addr_i | input | ADDR_W | Byte address of register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wake request |

## Verification
The hardest case to reach is a status word where several slots compete. This needs a lower-index slot that is valid and names an active source, a higher-index slot naming a different active source, and an invalid slot naming an active source, all at once. The stimulus builds that state step by step: it writes slots in non-monotonic order and enables sources in two banks. It then resteers the winner to the fast request so that arbitration falls back to the next slot. It also moves a source into the last bank to exercise the final slot address and the fourth bank base.

// File: rtl/plvl_intc_pkg.sv
package plvl_intc_pkg;

  localparam int LANES     = 32;
  localparam int MAX_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int PIDX_W    = 7;

  localparam logic [11:0] OFF_IRQP  = 12'h000;
  localparam logic [11:0] OFF_MASK  = 12'h004;
  localparam logic [11:0] OFF_ROUTE = 12'h008;
  localparam logic [11:0] OFF_FIQP  = 12'h00C;
  localparam logic [11:0] OFF_RAW   = 12'h010;
  localparam logic [11:0] OFF_CTRL  = 12'h014;
  localparam logic [11:0] OFF_HP    = 12'h018;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IRQP,
    SEL_MASK,
    SEL_ROUTE,
    SEL_FIQP,
    SEL_RAW,
    SEL_CTRL,
    SEL_HP,
    SEL_PRIO
  } sel_e;

  typedef struct packed {
    sel_e              sel;
    logic [BANK_W-1:0] bank;
    logic [PIDX_W-1:0] pidx;
  } dec_t;

  function automatic logic [11:0] bank_base(input int b);
    case (b)
      0:       return 12'h000;
      1:       return 12'h09C;
      2:       return 12'h130;
      default: return 12'h244;
    endcase
  endfunction

  function automatic logic [11:0] prio_addr(input int i);
    if (i < 32)      return 12'h01C + 12'(i * 4);
    else if (i < 64) return 12'h0B0 + 12'((i - 32) * 4);
    else             return 12'h144 + 12'((i - 64) * 4);
  endfunction

endpackage

// File: rtl/plvl_intc_decode.sv
module plvl_intc_decode
  import plvl_intc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  parameter int NSRC      = 32 * NUM_BANKS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  always_comb begin
    dec_o.sel  = SEL_NONE;
    dec_o.bank = '0;
    dec_o.pidx = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(bank_base(b) + OFF_IRQP)) begin
        dec_o.sel  = SEL_IRQP;
        dec_o.bank = BANK_W'(b);
      end
      if (addr_i == ADDR_W'(bank_base(b) + OFF_MASK)) begin
        dec_o.sel  = SEL_MASK;
        dec_o.bank = BANK_W'(b);
      end
      if (addr_i == ADDR_W'(bank_base(b) + OFF_ROUTE)) begin
        dec_o.sel  = SEL_ROUTE;
        dec_o.bank = BANK_W'(b);
      end
      if (addr_i == ADDR_W'(bank_base(b) + OFF_FIQP)) begin
        dec_o.sel  = SEL_FIQP;
        dec_o.bank = BANK_W'(b);
      end
      if (addr_i == ADDR_W'(bank_base(b) + OFF_RAW)) begin
        dec_o.sel  = SEL_RAW;
        dec_o.bank = BANK_W'(b);
      end
    end
    if (addr_i == ADDR_W'(OFF_CTRL)) dec_o.sel = SEL_CTRL;
    if (addr_i == ADDR_W'(OFF_HP))   dec_o.sel = SEL_HP;
    for (int i = 0; i < NSRC; i++) begin
      if (addr_i == ADDR_W'(prio_addr(i))) begin
        dec_o.sel  = SEL_PRIO;
        dec_o.pidx = PIDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/plvl_intc_bank.sv
module plvl_intc_bank
  import plvl_intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] src_i,
  input  logic [31:0]      wdata_i,
  input  logic             mask_we_i,
  input  logic             route_we_i,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] route_o,
  output logic [LANES-1:0] raw_o,
  output logic [LANES-1:0] irqp_o,
  output logic [LANES-1:0] fiqp_o
);

  logic [LANES-1:0] raw_q, mask_q, route_q;

  // Level capture: a pending bit only follows its line.
  always_ff @(posedge clk) raw_q <= src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (mask_we_i)  mask_q  <= wdata_i[LANES-1:0];
      if (route_we_i) route_q <= wdata_i[LANES-1:0];
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;
  assign raw_o   = raw_q;
  assign irqp_o  = raw_q & mask_q & ~route_q;
  assign fiqp_o  = raw_q & mask_q & route_q;

  assert_raw_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    raw_o == $past(src_i));

  assert_mask_zero_hides_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we_i && wdata_i[LANES-1:0] == '0) |=> (irqp_o == '0 && fiqp_o == '0));

endmodule

// File: rtl/plvl_intc_arb.sv
module plvl_intc_arb
  import plvl_intc_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int SRC_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PIDX_W-1:0] widx_i,
  input  logic              wvld_i,
  input  logic [SRC_W-1:0]  wnum_i,
  input  logic [PIDX_W-1:0] ridx_i,
  output logic [31:0]       rword_o,
  input  logic [NSRC-1:0]   act_i,
  output logic [31:0]       hp_word_o
);

  localparam int NPAD = 1 << SRC_W;

  logic [NSRC-1:0]  vld_q;
  logic [SRC_W-1:0] num_q [NSRC];
  logic [NPAD-1:0]  act_pad;
  logic             found;
  logic [SRC_W-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSRC; i++) num_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (we_i && widx_i == PIDX_W'(i)) begin
          vld_q[i] <= wvld_i;
          num_q[i] <= wnum_i;
        end
      end
    end
  end

  always_comb begin
    rword_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (ridx_i == PIDX_W'(i)) rword_o = {vld_q[i], 31'(num_q[i])};
    end
  end

  assign act_pad = NPAD'(act_i);

  // Walk from the least urgent slot down so the lowest index is written last.
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vld_q[i] && act_pad[num_q[i]]) begin
        found = 1'b1;
        win   = num_q[i];
      end
    end
  end

  assign hp_word_o = {|act_i, 15'(win), 16'h0000};

  assert_idle_field_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|act_i) |-> (hp_word_o[30:16] == 15'd0));

  assert_winner_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> act_pad[hp_word_o[16 +: SRC_W]]);

endmodule

// File: rtl/plvl_intc.sv
module plvl_intc
  import plvl_intc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [32*NUM_BANKS-1:0] src_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [31:0]             wdata_i,
  input  logic                    rd_en_i,
  output logic [31:0]             rdata_o,
  output logic                    rvalid_o,
  output logic                    irq_o,
  output logic                    fiq_o,
  output logic                    wake_o
);

  localparam int NSRC  = LANES * NUM_BANKS;
  localparam int SRC_W = $clog2(NSRC);

  dec_t             dec;
  logic [LANES-1:0] mask_w  [NUM_BANKS];
  logic [LANES-1:0] route_w [NUM_BANKS];
  logic [LANES-1:0] raw_w   [NUM_BANKS];
  logic [LANES-1:0] irqp_w  [NUM_BANKS];
  logic [LANES-1:0] fiqp_w  [NUM_BANKS];
  logic [NSRC-1:0]  irq_all, fiq_all, raw_all, mask_all;
  logic [31:0]      prio_rword, hp_word, rd_val, rdata_q;
  logic             ctrl_q, rvalid_q;

  plvl_intc_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .NSRC     (NSRC)
  ) u_decode (
    .addr_i(addr_i),
    .dec_o (dec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    plvl_intc_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[b*LANES +: LANES]),
      .wdata_i   (wdata_i),
      .mask_we_i (we_i && dec.sel == SEL_MASK  && dec.bank == BANK_W'(b)),
      .route_we_i(we_i && dec.sel == SEL_ROUTE && dec.bank == BANK_W'(b)),
      .mask_o    (mask_w[b]),
      .route_o   (route_w[b]),
      .raw_o     (raw_w[b]),
      .irqp_o    (irqp_w[b]),
      .fiqp_o    (fiqp_w[b])
    );
    assign irq_all [b*LANES +: LANES] = irqp_w[b];
    assign fiq_all [b*LANES +: LANES] = fiqp_w[b];
    assign raw_all [b*LANES +: LANES] = raw_w[b];
    assign mask_all[b*LANES +: LANES] = mask_w[b];
  end

  plvl_intc_arb #(
    .NSRC (NSRC),
    .SRC_W(SRC_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (we_i && dec.sel == SEL_PRIO),
    .widx_i   (dec.pidx),
    .wvld_i   (wdata_i[31]),
    .wnum_i   (wdata_i[SRC_W-1:0]),
    .ridx_i   (dec.pidx),
    .rword_o  (prio_rword),
    .act_i    (irq_all),
    .hp_word_o(hp_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctrl_q <= 1'b0;
    else if (we_i && dec.sel == SEL_CTRL) ctrl_q <= wdata_i[0];
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec.bank == BANK_W'(b)) begin
        case (dec.sel)
          SEL_IRQP:  rd_val = irqp_w[b];
          SEL_MASK:  rd_val = mask_w[b];
          SEL_ROUTE: rd_val = route_w[b];
          SEL_FIQP:  rd_val = fiqp_w[b];
          SEL_RAW:   rd_val = raw_w[b];
          default:   ;
        endcase
      end
    end
    case (dec.sel)
      SEL_CTRL: rd_val = {31'b0, ctrl_q};
      SEL_HP:   rd_val = hp_word;
      SEL_PRIO: rd_val = prio_rword;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = |irq_all;
  assign fiq_o    = |fiq_all;
  assign wake_o   = ctrl_q ? |(raw_all & mask_all) : |raw_all;

  assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);

  assert_status_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == hp_word[31]);

  assert_wake_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q && |raw_all) |-> wake_o);

  assert_irq_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> wake_o);

endmodule

// File: tb/plvl_intc_bench.sv
`timescale 1ns/1ps
module plvl_intc_bench;

  localparam int NB = 4;
  localparam int NS = 32 * NB;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   src = '0;
  logic [11:0]     addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic            rd_en = 1'b0;
  logic [31:0]     rdata;
  logic            rvalid, irq, fiq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Requirement-level model
  logic [31:0] m_mask [NB];
  logic [31:0] m_route[NB];
  logic        m_pv   [NS];
  logic [6:0]  m_pn   [NS];
  logic [NS-1:0] m_src;

  always #10 clk = ~clk;

  plvl_intc #(.NUM_BANKS(NB), .ADDR_W(12)) u_plvl_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .rvalid_o(rvalid),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  function automatic logic [11:0] bb(input int b);
    logic [11:0] t[4] = '{12'h000, 12'h09C, 12'h130, 12'h244};
    return t[b];
  endfunction

  function automatic logic [11:0] pa(input int i);
    if (i < 32) return 12'(28 + 4 * i);
    if (i < 64) return 12'(176 + 4 * (i - 32));
    return 12'(324 + 4 * (i - 64));
  endfunction

  function automatic logic [NS-1:0] m_act();
    logic [NS-1:0] a;
    for (int b = 0; b < NB; b++)
      a[b*32 +: 32] = m_src[b*32 +: 32] & m_mask[b] & ~m_route[b];
    return a;
  endfunction

  function automatic logic [31:0] exp_hp();
    logic [NS-1:0] a = m_act();
    logic [6:0] w = '0;
    bit f = 0;
    for (int i = 0; i < NS; i++)
      if (!f && m_pv[i] && a[m_pn[i]]) begin f = 1; w = m_pn[i]; end
    return {|a, 8'b0, w, 16'h0};
  endfunction

  function automatic logic [31:0] exp_fiqp(input int b);
    return m_src[b*32 +: 32] & m_mask[b] & m_route[b];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_mask(input int b, input logic [31:0] v);
    wr(bb(b) + 12'h004, v); m_mask[b] = v;
  endtask

  task automatic set_route(input int b, input logic [31:0] v);
    wr(bb(b) + 12'h008, v); m_route[b] = v;
  endtask

  task automatic set_prio(input int i, input logic [31:0] v);
    wr(pa(i), v); m_pv[i] = v[31]; m_pn[i] = v[6:0];
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk);
    src = v; m_src = v;
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R13: unexpected read data %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_mask[b] = '0; m_route[b] = '0; end
    for (int i = 0; i < NS; i++) begin m_pv[i] = 1'b0; m_pn[i] = '0; end
    m_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int b = 0; b < NB; b++) rd(bb(b) + 12'h004, 32'h0, "R1 mask");
    rd(bb(1) + 12'h008, 32'h0, "R1 route");
    rd(12'h014, 32'h0, "R1 ctrl");
    rd(pa(0), 32'h0, "R1 slot0");
    rd(pa(100), 32'h0, "R1 slot100");
    rd(12'h018, 32'h0, "R1 status");
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 wake", {31'b0, wake}, 32'h0);
    chk("R13 idle rvalid", {31'b0, rvalid}, 32'h0);

    // R2 raw levels, R6 wake on raw with ctrl clear
    begin
      automatic logic [NS-1:0] v = '0;
      v[5] = 1'b1; v[67] = 1'b1;
      set_src(v);
    end
    rd(bb(0) + 12'h010, 32'h0000_0020, "R2 raw bank0");
    rd(bb(2) + 12'h010, 32'h0000_0008, "R2 raw bank2");
    rd(bb(0) + 12'h000, 32'h0, "R3 masked hidden");
    @(negedge clk);
    chk("R6 wake raw", {31'b0, wake}, 32'h1);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    wr(bb(0) + 12'h010, 32'h0);
    rd(bb(0) + 12'h010, 32'h0000_0020, "R2 raw write ignored");

    // R3 / R5 / R10 enable bank0, no slots valid
    set_mask(0, 32'hFFFF_FFFF);
    rd(bb(0) + 12'h000, 32'h0000_0020, "R3 masked pending");
    rd(12'h018, exp_hp(), "R10 no slot match");
    @(negedge clk);
    chk("R5 irq", {31'b0, irq}, 32'h1);

    // R8 / R9 slot arbitration
    set_prio(3, 32'h8000_0005);
    rd(12'h018, 32'h8005_0000, "R9 single slot");
    set_mask(2, 32'h0000_0008);
    set_prio(1, 32'h8000_0043);
    rd(12'h018, 32'h8043_0000, "R9 lower slot wins");
    set_prio(0, 32'h0000_0005);
    rd(12'h018, exp_hp(), "R9 invalid slot ignored");
    rd(pa(0), 32'h0000_0005, "R8 invalid readback");
    set_prio(2, 32'hFFFF_FFFF);
    rd(pa(2), 32'h8000_007F, "R8 field readback");
    rd(12'h018, 32'h8043_0000, "R9 inactive source");

    // R4 / R11 steering to the fast request
    set_route(2, 32'h0000_0008);
    rd(bb(2) + 12'h00C, exp_fiqp(2), "R4 fast pending");
    rd(bb(2) + 12'h000, 32'h0, "R4 normal cleared");
    rd(12'h018, 32'h8005_0000, "R11 fast source skipped");
    @(negedge clk);
    chk("R5 fiq", {31'b0, fiq}, 32'h1);
    set_route(0, 32'h0000_0020);
    rd(12'h018, 32'h0, "R10 status clear");
    @(negedge clk);
    chk("R5 irq off", {31'b0, irq}, 32'h0);
    chk("R5 fiq on", {31'b0, fiq}, 32'h1);

    // R6 wake qualified by enable
    wr(12'h014, 32'h1);
    set_mask(0, 32'h0);
    set_mask(2, 32'h0);
    rd(12'h014, 32'h1, "R6 ctrl readback");
    rd(bb(0) + 12'h00C, 32'h0, "R3 mask zero hides");
    @(negedge clk);
    chk("R6 wake gated", {31'b0, wake}, 32'h0);
    wr(12'h014, 32'h0);
    @(negedge clk);
    chk("R6 wake raw again", {31'b0, wake}, 32'h1);

    // R12 unmapped addresses
    wr(12'h258, 32'hDEAD_BEEF);
    wr(12'h006, 32'hFFFF_FFFF);
    rd(12'h258, 32'h0, "R12 unmapped read");
    rd(12'h006, 32'h0, "R12 misaligned read");
    rd(bb(0) + 12'h004, 32'h0, "R12 write ignored");
    rd(12'h014, 32'h0, "R12 ctrl untouched");

    // R2 level drop clears pending
    set_src('0);
    rd(bb(0) + 12'h010, 32'h0, "R2 level dropped");
    @(negedge clk);
    chk("R2 fiq after drop", {31'b0, fiq}, 32'h0);

    // R7 / R8 last bank and last slot
    set_mask(3, 32'h8000_0000);
    rd(bb(3) + 12'h004, 32'h8000_0000, "R7 bank3 mask");
    begin
      automatic logic [NS-1:0] v = '0;
      v[127] = 1'b1;
      set_src(v);
    end
    rd(bb(3) + 12'h000, 32'h8000_0000, "R7 bank3 pending");
    set_prio(127, 32'h8000_007F);
    rd(pa(127), 32'h8000_007F, "R8 last slot");
    rd(12'h018, 32'h807F_0000, "R9 last bank winner");

    repeat (4) @(negedge clk);
    chk("R13 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule